// File: doc/BRIEF.md
# Level-Sensitive Vectored Interrupt Controller

This block gathers up to 96 level-sensitive interrupt sources into three 32-bit pending words. From them it drives two processor request lines, a normal interrupt and a fast interrupt. It also produces a vector that points at the lowest-numbered source that is both pending and unmasked. Software sees the state through a simple word-addressed register bus. Writes are single-cycle strobes. Read data follows the address combinationally. The block occupies a 1 KB window.

Each source is sampled into its pending bit on every clock. Request lines and the vector are decoded from this registered state, so they react in the cycle after an input or register change. A per-source select word routes sources onto the fast line. Those hits are also latched into fast-pending words, which software clears by writing ones.

Top module: `vec_intc`

## Requirements
- R1: Pending bit n (word n/32, bit n%32) equals `src_i[n]` as sampled at the previous rising clock edge.
- R2: `irq_o` is high exactly when some pending bit has a clear mask bit. Enable words never affect `irq_o`, `fiq_o` or the vector.
- R3: `fiq_o` is high exactly when some source is pending, unmasked and has its select bit set.
- R4: The vector (`vec_o`, and read data at offset 0x00) is 4 times the index of the lowest-numbered pending unmasked source. It is 0 when there is none.
- R5: Map: vector 0x00, base 0x04, protect 0x08, NMI 0x0C. The word arrays are pending 0x10, fast-pending 0x20, select 0x30, enable 0x40 and mask 0x50. In each array, offset bits [3:2] pick word 0..2.
- R6: Writes to the pending words are ignored.
- R7: Each fast-pending bit sets on every cycle in which its source is pending, unmasked and selected. A write to a fast-pending word clears the bits that are 1 in the write data. A set in the same cycle wins over the clear.
- R8: A write to the base register stores the data with bits [1:0] forced to 0.
- R9: Select, enable, mask, protect and NMI store written data unchanged.
- R10: Reset sets every register, the pending words, both request lines and the vector to zero.
- R11: Any other offset is undecoded. This includes word index 3 of an array, a non-zero bits [1:0] and offsets 0x60 and up. Undecoded offsets read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 96 | Level-sensitive interrupt sources |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 10 | Byte offset within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| vec_o | output | 32 | Vector of the lowest active source |

## Verification
The bench checks the vector at source 0, at the first bit of a later word and at source 95. A design that scans in the wrong order, or forgets the times-four scaling, returns a wrong offset there. The bench also covers a source 0 that is active but masked: that case must give vector 0 with irq low.

Enable is set while mask is clear, and an enable-gated design would then drop the request lines. A write-one-to-clear of fast-pending bits is issued while the hit persists and again after it is gone, so a design with the wrong set/clear priority leaves stale or missing bits. Writes go to the pending words, to word index 3 and to misaligned offsets, and a design that decodes loosely corrupts a neighbouring word.

// File: rtl/vic_pkg.sv
package vic_pkg;
  parameter int unsigned WORD_W    = 32;
  parameter int unsigned NUM_WORDS = 3;
  parameter int unsigned ADDR_W    = 10;
  localparam int unsigned NUM_SRC  = WORD_W * NUM_WORDS;
  localparam int unsigned SRC_IW   = $clog2(NUM_SRC);

  // offset bits [7:4]
  typedef enum logic [3:0] {
    GRP_CTRL  = 4'h0,
    GRP_PEND  = 4'h1,
    GRP_FPEND = 4'h2,
    GRP_SEL   = 4'h3,
    GRP_EN    = 4'h4,
    GRP_MASK  = 4'h5
  } grp_e;

  // control group word index, offset bits [3:2]
  typedef enum logic [1:0] {
    CTL_VEC  = 2'd0,
    CTL_BASE = 2'd1,
    CTL_PROT = 2'd2,
    CTL_NMI  = 2'd3
  } ctl_e;

  typedef struct packed {
    logic       valid;
    logic [3:0] grp;
    logic [1:0] idx;
  } dec_t;
endpackage

// File: rtl/vic_decode.sv
module vic_decode
  import vic_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic hi_zero;
  logic grp_ok;
  logic idx_ok;

  always_comb begin
    hi_zero = (addr_i[ADDR_W-1:8] == '0) && (addr_i[1:0] == 2'b00);
    grp_ok  = (addr_i[7:4] <= GRP_MASK);
    idx_ok  = (addr_i[7:4] == GRP_CTRL) || (32'(addr_i[3:2]) < NUM_WORDS);
    dec_o.valid = hi_zero && grp_ok && idx_ok;
    dec_o.grp   = addr_i[7:4];
    dec_o.idx   = addr_i[3:2];
  end
endmodule

// File: rtl/vic_pending.sv
module vic_pending
  import vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  output logic [NUM_SRC-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= src_i;
  end

  a_r1_pend_tracks_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> pend_o == $past(src_i));
endmodule

// File: rtl/vic_resolve.sv
module vic_resolve
  import vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] sel_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [NUM_SRC-1:0] fiq_hit_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [WORD_W-1:0]  vec_o
);
  logic [NUM_SRC-1:0]   act;
  logic [NUM_WORDS-1:0] word_act;
  logic [SRC_IW-1:0]    first;

  assign act       = pend_i & ~mask_i;
  assign fiq_hit_o = act & sel_i;

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      assign word_act[w] = |act[w*WORD_W +: WORD_W];
    end
  endgenerate

  assign irq_o = |word_act;
  assign fiq_o = |fiq_hit_o;

  // lowest index wins: scan downward, last hit kept
  always_comb begin
    first = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (act[i]) first = SRC_IW'(i);
    end
    vec_o = irq_o ? (WORD_W'(first) << 2) : '0;
  end

  a_r3_fiq_needs_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fiq_o |-> irq_o);
  a_r4_vec_zero_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_o |-> vec_o == '0);
  a_r4_vec_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_o[1:0] == 2'b00);
endmodule

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  dec_t               dec_i,
  input  logic [WORD_W-1:0]  wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] fiq_hit_i,
  input  logic [WORD_W-1:0]  vec_i,
  output logic [NUM_SRC-1:0] sel_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [WORD_W-1:0]  rdata_o
);
  logic [WORD_W-1:0]  base_q, prot_q, nmi_q;
  logic [NUM_SRC-1:0] fpend_q, sel_q, en_q, mask_q;
  logic               wr;

  assign wr = we_i && dec_i.valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else if (wr && dec_i.grp == GRP_CTRL) begin
      case (ctl_e'(dec_i.idx))
        CTL_BASE: base_q <= {wdata_i[WORD_W-1:2], 2'b00};
        CTL_PROT: prot_q <= wdata_i;
        CTL_NMI:  nmi_q  <= wdata_i;
        default: ;
      endcase
    end
  end

  genvar w;
  generate
    for (w = 0; w < NUM_WORDS; w++) begin : g_word
      logic hit;
      logic [WORD_W-1:0] clr;
      assign hit = wr && (32'(dec_i.idx) == w);
      assign clr = (hit && dec_i.grp == GRP_FPEND) ? wdata_i : '0;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          fpend_q[w*WORD_W +: WORD_W] <= '0;
          sel_q[w*WORD_W +: WORD_W]   <= '0;
          en_q[w*WORD_W +: WORD_W]    <= '0;
          mask_q[w*WORD_W +: WORD_W]  <= '0;
        end else begin
          // set wins over clear
          fpend_q[w*WORD_W +: WORD_W] <= (fpend_q[w*WORD_W +: WORD_W] & ~clr)
                                         | fiq_hit_i[w*WORD_W +: WORD_W];
          if (hit && dec_i.grp == GRP_SEL)  sel_q[w*WORD_W +: WORD_W]  <= wdata_i;
          if (hit && dec_i.grp == GRP_EN)   en_q[w*WORD_W +: WORD_W]   <= wdata_i;
          if (hit && dec_i.grp == GRP_MASK) mask_q[w*WORD_W +: WORD_W] <= wdata_i;
        end
      end
    end
  endgenerate

  assign sel_o  = sel_q;
  assign mask_o = mask_q;

  always_comb begin
    rdata_o = '0;
    if (dec_i.valid) begin
      unique case (grp_e'(dec_i.grp))
        GRP_CTRL: begin
          case (ctl_e'(dec_i.idx))
            CTL_VEC:  rdata_o = vec_i;
            CTL_BASE: rdata_o = base_q;
            CTL_PROT: rdata_o = prot_q;
            CTL_NMI:  rdata_o = nmi_q;
            default:  rdata_o = '0;
          endcase
        end
        GRP_PEND:  rdata_o = pend_i[dec_i.idx*WORD_W +: WORD_W];
        GRP_FPEND: rdata_o = fpend_q[dec_i.idx*WORD_W +: WORD_W];
        GRP_SEL:   rdata_o = sel_q[dec_i.idx*WORD_W +: WORD_W];
        GRP_EN:    rdata_o = en_q[dec_i.idx*WORD_W +: WORD_W];
        GRP_MASK:  rdata_o = mask_q[dec_i.idx*WORD_W +: WORD_W];
        default:   rdata_o = '0;
      endcase
    end
  end

  a_r11_bad_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !dec_i.valid) |=> ($stable(sel_q) && $stable(en_q) && $stable(mask_q)
                                && $stable(base_q) && $stable(prot_q) && $stable(nmi_q)));
  a_r7_w1c_word0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && dec_i.grp == GRP_FPEND && dec_i.idx == 2'd0
     && ((fiq_hit_i[WORD_W-1:0] & wdata_i) == '0))
    |=> ((fpend_q[WORD_W-1:0] & $past(wdata_i) & ~$past(fiq_hit_i[WORD_W-1:0])) == '0));
  a_r8_base_low_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i.valid && dec_i.grp == GRP_CTRL && dec_i.idx == 2'd1) |-> rdata_o[1:0] == 2'b00);
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vic_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [WORD_W-1:0]  wdata_i,
  output logic [WORD_W-1:0]  rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [WORD_W-1:0]  vec_o
);
  dec_t               dec;
  logic [NUM_SRC-1:0] pend, sel, mask, fiq_hit;

  vic_decode u_dec (.addr_i(addr_i), .dec_o(dec));

  vic_pending u_pend (.clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .pend_o(pend));

  vic_resolve u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .pend_i(pend), .sel_i(sel), .mask_i(mask),
    .fiq_hit_o(fiq_hit), .irq_o(irq_o), .fiq_o(fiq_o), .vec_o(vec_o)
  );

  vic_regs u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .dec_i(dec), .wdata_i(wdata_i),
    .pend_i(pend), .fiq_hit_i(fiq_hit), .vec_i(vec_o),
    .sel_o(sel), .mask_o(mask), .rdata_o(rdata_o)
  );

  // R4: vector names an active source
  a_r4_vec_hits_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend[vec_o[SRC_IW+1:2]] && !mask[vec_o[SRC_IW+1:2]]));
  a_r2_irq_from_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (pend != '0));
endmodule

// File: tb/tb_vec_intc.sv
module tb_vec_intc;
  localparam int NS = 96;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, vec;
  logic        irq, fiq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  vec_intc dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq), .vec_o(vec)
  );

  // reference model
  bit [NS-1:0] m_pend, m_fp, m_sel, m_en, m_mask;
  bit [31:0]   m_base, m_prot, m_nmi;

  function automatic bit [31:0] m_vec();
    for (int i = 0; i < NS; i++)
      if (m_pend[i] && !m_mask[i]) return 32'(i * 4);
    return 0;
  endfunction

  function automatic bit [31:0] m_read(input bit [9:0] a);
    int g, k;
    if (a[9:8] != 0 || a[1:0] != 0) return 0;
    g = int'(a[7:4]); k = int'(a[3:2]);
    if (g == 0) begin
      case (k)
        0: return m_vec();
        1: return m_base;
        2: return m_prot;
        default: return m_nmi;
      endcase
    end
    if (g > 5 || k > 2) return 0;
    case (g)
      1: return m_pend[k*32 +: 32];
      2: return m_fp[k*32 +: 32];
      3: return m_sel[k*32 +: 32];
      4: return m_en[k*32 +: 32];
      default: return m_mask[k*32 +: 32];
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend = 0; m_fp = 0; m_sel = 0; m_en = 0; m_mask = 0;
      m_base = 0; m_prot = 0; m_nmi = 0;
    end else begin
      bit [NS-1:0] hit, clr;
      int g, k;
      hit = m_pend & ~m_mask & m_sel;
      clr = 0;
      g = int'(addr[7:4]); k = int'(addr[3:2]);
      if (we && addr[9:8] == 0 && addr[1:0] == 0) begin
        if (g == 0) begin
          if (k == 1) m_base = {wdata[31:2], 2'b00};
          if (k == 2) m_prot = wdata;
          if (k == 3) m_nmi = wdata;
        end else if (k <= 2) begin
          if (g == 2) clr[k*32 +: 32] = wdata;
          if (g == 3) m_sel[k*32 +: 32] = wdata;
          if (g == 4) m_en[k*32 +: 32] = wdata;
          if (g == 5) m_mask[k*32 +: 32] = wdata;
        end
      end
      m_fp = (m_fp & ~clr) | hit;
      m_pend = src;
    end
  end

  task automatic chk(input string req, input string what, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // every-cycle output comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "irq_o", 32'(irq), 32'(m_vec() != 0 || (m_pend[0] && !m_mask[0])));
      chk("R3", "fiq_o", 32'(fiq), 32'(|(m_pend & ~m_mask & m_sel)));
      chk("R4", "vec_o", vec, m_vec());
    end
  end

  task automatic wr(input bit [9:0] a, input bit [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input string req, input bit [9:0] a);
    addr = a;
    #2;
    chk(req, $sformatf("read %h", a), rdata, m_read(a));
  endtask

  task automatic rd_exp(input string req, input bit [9:0] a, input bit [31:0] e);
    addr = a;
    #2;
    chk(req, $sformatf("read %h", a), rdata, e);
  endtask

  task automatic settle(input bit [NS-1:0] s);
    src = s;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 50000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", "irq", 32'(irq), 0);
    chk("R10", "fiq", 32'(fiq), 0);
    chk("R10", "vec", vec, 0);
    for (int a = 0; a < 'h60; a += 4) rd_exp("R10", 10'(a), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R4: single sources across words
    settle(96'd1 << 95);
    rd_exp("R4", 10'h000, 32'd380);
    rd_exp("R1", 10'h018, 32'h8000_0000);
    settle(96'd1 << 32);
    rd_exp("R4", 10'h000, 32'd128);
    rd_exp("R1", 10'h014, 32'h0000_0001);
    settle((96'd1 << 40) | (96'd1 << 5) | (96'd1 << 95));
    rd_exp("R4", 10'h000, 32'd20);
    settle(96'd1);
    rd_exp("R4", 10'h000, 32'd0);
    chk("R4", "irq with src0", 32'(irq), 1);

    // R2 / R9: mask and enable
    wr(10'h050, 32'h0000_0001);
    rd_exp("R9", 10'h050, 32'h1);
    chk("R2", "masked src0 irq", 32'(irq), 0);
    chk("R4", "masked src0 vec", vec, 0);
    settle(96'd1 | (96'd1 << 70));
    rd_exp("R4", 10'h000, 32'd280);
    wr(10'h040, 32'hFFFF_FFFF);
    wr(10'h044, 32'h0);
    wr(10'h048, 32'h0);
    rd_exp("R9", 10'h040, 32'hFFFF_FFFF);
    chk("R2", "enable ignored irq", 32'(irq), 1);

    // R3 / R7: select and fast-pending
    wr(10'h038, 32'h0000_0040);   // source 70 selected
    @(negedge clk);
    chk("R3", "fiq on select", 32'(fiq), 1);
    rd_exp("R7", 10'h028, 32'h0000_0040);
    wr(10'h028, 32'h0000_0040);   // clear while hit persists
    rd_exp("R7", 10'h028, 32'h0000_0040);
    settle(96'd1);
    @(negedge clk);
    wr(10'h028, 32'h0000_0040);   // clear after hit gone
    rd_exp("R7", 10'h028, 32'h0);
    chk("R3", "fiq gone", 32'(fiq), 0);

    // R6: pending writes ignored
    settle(96'd1 << 33);
    wr(10'h014, 32'hFFFF_FFFF);
    rd_exp("R6", 10'h014, 32'h0000_0002);
    wr(10'h010, 32'h0);
    rd_exp("R6", 10'h010, 32'h0000_0001 & 32'(src[31:0]));

    // R8 / R9: control registers
    wr(10'h004, 32'hFFFF_FFFF);
    rd_exp("R8", 10'h004, 32'hFFFF_FFFC);
    wr(10'h008, 32'hA5A5_0003);
    rd_exp("R9", 10'h008, 32'hA5A5_0003);
    wr(10'h00C, 32'h1234_5677);
    rd_exp("R9", 10'h00C, 32'h1234_5677);
    wr(10'h000, 32'hFFFF_FFFF);
    rd("R4", 10'h000);

    // R5 / R11: decode boundaries
    wr(10'h054, 32'hDEAD_BEEF);
    rd_exp("R5", 10'h054, 32'hDEAD_BEEF);
    rd_exp("R5", 10'h050, 32'h1);
    wr(10'h05C, 32'hFFFF_FFFF);
    wr(10'h052, 32'hFFFF_FFFF);
    wr(10'h060, 32'hFFFF_FFFF);
    wr(10'h104, 32'h0);
    rd_exp("R11", 10'h05C, 0);
    rd_exp("R11", 10'h060, 0);
    rd_exp("R11", 10'h3FC, 0);
    rd_exp("R11", 10'h052, 0);
    rd_exp("R11", 10'h050, 32'h1);
    rd_exp("R11", 10'h058, 32'h0);
    rd_exp("R11", 10'h004, 32'hFFFF_FFFC);

    // R1: pattern sweep
    for (int i = 0; i < 12; i++) begin
      settle({32'(i * 32'h9E37_79B9), 32'(i * 32'h85EB_CA6B), 32'(i * 32'hC2B2_AE35)});
      rd("R1", 10'h010);
      rd("R1", 10'h018);
      rd("R7", 10'h020);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule